// File: doc/BRIEF.md
# Modular Inverse Widening Unit

This block takes an odd integer of up to 64 bits together with a 16-bit inverse of that integer modulo 2^16. It returns the exact multiplicative inverse modulo 2^32 or 2^64. Each refinement pass forms t = i·x, then x' = x·(2 − t). All arithmetic wraps modulo 2^64, and the pass masks its result to the selected output width. Every pass doubles the count of correct low-order bits. Bits above the target width are dropped rather than rounded, so the answer is exact. One pass widens a 16-bit seed to 32 bits, and two passes widen it to 64 bits.

A self-test mode discards the external seed. It starts instead from the operand's own three lowest bits, which hold a valid inverse modulo 8 because every odd residue mod 8 is its own inverse. In this mode the unit runs four or five passes. The products come from a serial shift-and-add multiplier. That multiplier takes one clock per operand bit.

A request is accepted by a start pulse while the unit is idle. An even operand has no inverse: it completes at once with an error flag and a zero result. Results are offered with a valid flag and held until the consumer raises ready.

Top module: `minv_refine_top`

## Requirements
- R1: With `wide_i`=0 (32-bit target), a valid result r satisfies r·operand ≡ 1 (mod 2^32), and r[63:32] = 0.
- R2: With `wide_i`=1 (64-bit target), a valid result r satisfies r·operand ≡ 1 (mod 2^64).
- R3: With `selftest_i`=0, `seed_i` is taken as the inverse of the operand modulo 2^16 and the unit runs 1 refinement pass for 32 bits or 2 passes for 64 bits.
- R4: With `selftest_i`=1, `seed_i` has no effect: the start value is operand[2:0], valid to 3 bits, and the unit runs 4 passes for 32 bits or 5 passes for 64 bits.
- R5: An accepted even operand (bit 0 = 0) gives `out_valid_o`=1, `err_o`=1 and `result_o`=0 right after the accepting edge, with no refinement.
- R6: While `out_valid_o`=1 and `out_ready_i`=0, the valid flag, result and error flag hold. An edge with `out_ready_i`=1 clears `out_valid_o`.
- R7: `start_i` is ignored unless the unit is idle (neither computing nor holding a result). A start during that time changes neither the pending result nor the next state.
- R8: In 32-bit mode, operand bits 63:32 have no effect on the result.
- R9: After reset, `out_valid_o`=0, `err_o`=0 and `result_o`=0.
- R10: For an odd operand, `out_valid_o` rises exactly N·2·(64+2) cycles after the accepting edge, where N is the pass count of R3/R4 (132, 264, 528 or 660 cycles).
- R11: For an odd operand, `err_o`=0 with the result, also after an earlier even request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| start_i | input | 1 | Request pulse, taken only while idle |
| operand_i | input | 64 | Integer to invert |
| seed_i | input | 16 | Inverse of operand modulo 2^16 (seed mode) |
| wide_i | input | 1 | Target width: 0 = 32 bits, 1 = 64 bits |
| selftest_i | input | 1 | 1 = start from operand[2:0] and ignore seed_i |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 64 | Inverse, zero-extended in 32-bit mode |
| err_o | output | 1 | Operand was even |

## Verification
A fault in the serial multiplier or in the correction term spoils the low bits of x from the pass where it occurs. It therefore shows as a product r·operand other than 1 in the very result that follows. A wrong pass count or a stuck multiplier counter moves the valid flag off its expected cycle by a multiple of 66 clocks. It can also leave the flag low, which the bench's poll limit reports within a few thousand cycles. A corrupted mode or width register at acceptance shows as nonzero upper bits, a seed that influences self-test results, or an operand that changes the pending result. Each of these appears at the handshake of the same request.

// File: rtl/minv_pkg.sv
package minv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROD = 2'd1,
    ST_CORR = 2'd2,
    ST_DONE = 2'd3
  } minv_state_e;

  localparam int unsigned SELF_SEED_BITS = 3;
endpackage

// File: rtl/minv_serial_mul.sv
// Serial shift-and-add multiplier, result modulo 2^W, one operand bit per clock.
module minv_serial_mul #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic [W-1:0] prod_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  a_q, a_d, b_q, b_d, acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, done_q, done_d;
  logic          en;

  assign en = go_i | run_q;

  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go_i) begin
      a_d   = a_i;
      b_d   = b_i;
      acc_d = '0;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (b_q[0]) acc_d = acc_q + a_q;
      a_d   = {a_q[W-2:0], 1'b0};
      b_d   = {1'b0, b_q[W-1:1]};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (en) begin
        a_q   <= a_d;
        b_q   <= b_d;
        acc_q <= acc_d;
        cnt_q <= cnt_d;
        run_q <= run_d;
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = acc_q;
endmodule

// File: rtl/minv_seed_sel.sv
// Picks the starting inverse and the number of bits it is known to be correct.
module minv_seed_sel #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEED_W = 16,
  parameter int unsigned PW     = 8
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              selftest_i,
  output logic [DATA_W-1:0] x0_o,
  output logic [PW-1:0]     prec0_o
);
  import minv_pkg::*;
  localparam int unsigned SB = SELF_SEED_BITS;

  always_comb begin
    x0_o = '0;
    if (selftest_i) begin
      x0_o[SB-1:0] = operand_i[SB-1:0];
      prec0_o      = PW'(SB);
    end else begin
      x0_o[SEED_W-1:0] = seed_i;
      prec0_o          = PW'(SEED_W);
    end
  end
endmodule

// File: rtl/minv_refine_top.sv
module minv_refine_top #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEED_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              wide_i,
  input  logic              selftest_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] result_o,
  output logic              err_o
);
  import minv_pkg::*;

  localparam int unsigned NARROW_W = DATA_W / 2;
  localparam int unsigned PW       = $clog2(2 * DATA_W) + 1;
  localparam logic [DATA_W-1:0] FULL_MASK   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] NARROW_MASK = {{NARROW_W{1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [PW-1:0] TGT_WIDE   = PW'(DATA_W);
  localparam logic [PW-1:0] TGT_NARROW = PW'(NARROW_W);
  localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

  minv_state_e       state_q, state_d;
  logic [DATA_W-1:0] x_q, x_d, corr_q, corr_d, op_q, op_d, res_q, res_d;
  logic [PW-1:0]     prec_q, prec_d;
  logic              wide_q, wide_d, err_q, err_d, launch_q, launch_d;

  logic              accept;
  logic [DATA_W-1:0] in_mask, cur_mask;
  logic [PW-1:0]     tgt_bits, prec_dbl;
  logic [DATA_W-1:0] seed_x0;
  logic [PW-1:0]     seed_prec;
  logic [DATA_W-1:0] mul_a, mul_b, mul_prod;
  logic              mul_done;

  minv_seed_sel #(.DATA_W(DATA_W), .SEED_W(SEED_W), .PW(PW)) seed_i0 (
    .operand_i (operand_i),
    .seed_i    (seed_i),
    .selftest_i(selftest_i),
    .x0_o      (seed_x0),
    .prec0_o   (seed_prec)
  );

  assign mul_a = (state_q == ST_PROD) ? op_q : x_q;
  assign mul_b = (state_q == ST_PROD) ? x_q  : corr_q;

  minv_serial_mul #(.W(DATA_W)) mul_i0 (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (launch_q),
    .a_i   (mul_a),
    .b_i   (mul_b),
    .done_o(mul_done),
    .prod_o(mul_prod)
  );

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign in_mask  = wide_i ? FULL_MASK : NARROW_MASK;
  assign cur_mask = wide_q ? FULL_MASK : NARROW_MASK;
  assign tgt_bits = wide_q ? TGT_WIDE : TGT_NARROW;
  assign prec_dbl = {prec_q[PW-2:0], 1'b0};

  always_comb begin
    state_d  = state_q;
    x_d      = x_q;
    corr_d   = corr_q;
    op_d     = op_q;
    wide_d   = wide_q;
    prec_d   = prec_q;
    res_d    = res_q;
    err_d    = err_q;
    launch_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          op_d   = operand_i & in_mask;
          wide_d = wide_i;
          if (!operand_i[0]) begin
            err_d   = 1'b1;
            res_d   = '0;
            state_d = ST_DONE;
          end else begin
            err_d    = 1'b0;
            x_d      = seed_x0;
            prec_d   = seed_prec;
            launch_d = 1'b1;
            state_d  = ST_PROD;
          end
        end
      end
      ST_PROD: begin
        if (mul_done) begin
          corr_d   = TWO - mul_prod;
          launch_d = 1'b1;
          state_d  = ST_CORR;
        end
      end
      ST_CORR: begin
        if (mul_done) begin
          x_d    = mul_prod & cur_mask;
          prec_d = prec_dbl;
          if (prec_dbl >= tgt_bits) begin
            res_d   = mul_prod & cur_mask;
            state_d = ST_DONE;
          end else begin
            launch_d = 1'b1;
            state_d  = ST_PROD;
          end
        end
      end
      default: begin
        if (out_ready_i) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      x_q      <= '0;
      corr_q   <= '0;
      op_q     <= '0;
      wide_q   <= 1'b0;
      prec_q   <= '0;
      res_q    <= '0;
      err_q    <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      x_q      <= x_d;
      corr_q   <= corr_d;
      op_q     <= op_d;
      wide_q   <= wide_d;
      prec_q   <= prec_d;
      res_q    <= res_d;
      err_q    <= err_d;
      launch_q <= launch_d;
    end
  end

  assign out_valid_o = (state_q == ST_DONE);
  assign result_o    = res_q;
  assign err_o       = err_q;
endmodule

// File: rtl/minv_refine_chk.sv
module minv_refine_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              op_lsb_i,
  input logic              accept_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] result_o,
  input logic              err_o,
  input logic [DATA_W-1:0] op_q,
  input logic              wide_q
);
  localparam int unsigned NW = DATA_W / 2;
  logic [DATA_W-1:0] chk_mask, chk_prod;

  assign chk_mask = wide_q ? {DATA_W{1'b1}} : {{NW{1'b0}}, {NW{1'b1}}};
  assign chk_prod = result_o * op_q;

  // R1 and R2: product of result and operand is one modulo the chosen width
  a_r2_product_one: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !err_o) |-> ((chk_prod & chk_mask) == DATA_W'(1)));

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !wide_q) |-> (result_o[DATA_W-1:NW] == '0));

  a_r5_even_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !op_lsb_i) |=> (out_valid_o && err_o));

  a_r5_even_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && err_o) |-> (result_o == '0));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(result_o) && $stable(err_o)));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i) |=> !out_valid_o);

  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !accept_i) |=> $stable(op_q));

  a_r11_no_err_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && op_q[0]) |-> !err_o);
endmodule

bind minv_refine_top minv_refine_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .op_lsb_i   (operand_i[0]),
  .accept_i   (accept),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .result_o   (result_o),
  .err_o      (err_o),
  .op_q       (op_q),
  .wide_q     (wide_q)
);

// File: tb/minv_refine_top_tb_top.sv
module minv_refine_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int NVEC = 14;
  localparam int POLL_MAX = 5000;

  // {operand, wide, selftest}
  localparam logic [65:0] VEC [NVEC] = '{
    {64'h0000_0000_0000_0001, 1'b0, 1'b0},
    {64'h0000_0000_0000_0003, 1'b0, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0},
    {64'h5555_5555_5555_5555, 1'b1, 1'b0},
    {64'h1234_5678_9ABC_DEF1, 1'b1, 1'b0},
    {64'hDEAD_BEEF_0000_0001, 1'b0, 1'b0},
    {64'h0000_0000_8000_0001, 1'b0, 1'b0},
    {64'h8000_0000_0000_0001, 1'b1, 1'b0},
    {64'h0000_0000_0001_0001, 1'b1, 1'b1},
    {64'hCAFE_F00D_1357_9BDF, 1'b1, 1'b1},
    {64'h0000_0000_FFFF_FFFD, 1'b0, 1'b1},
    {64'h0000_0000_0000_0007, 1'b0, 1'b1},
    {64'hA5A5_A5A5_A5A5_A5A5, 1'b1, 1'b0},
    {64'h0F0F_0F0F_0F0F_0F0B, 1'b0, 1'b0}
  };

  logic clk, rst_n, start, wide, self_t, ready, valid, err;
  logic [63:0] operand, result;
  logic [15:0] seed;
  int n_checks, n_errs;

  minv_refine_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .operand_i(operand),
    .seed_i(seed), .wide_i(wide), .selftest_i(self_t),
    .out_valid_o(valid), .out_ready_i(ready), .result_o(result), .err_o(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Bit-serial construction of the inverse modulo 2^64, independent of the refinement method
  function automatic logic [63:0] ref_inv(input logic [63:0] v);
    logic [63:0] r, p;
    r = 64'd1;
    for (int k = 1; k < 64; k++) begin
      p = v * r;
      if (p[k]) r[k] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [63:0] exp_inv(input logic [63:0] v, input logic w);
    logic [63:0] r;
    r = ref_inv(v);
    if (!w) r[63:32] = 32'h0;
    return r;
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [63:0] op, input logic [15:0] sd,
                        input logic w, input logic st);
    @(negedge clk);
    operand = op; seed = sd; wide = w; self_t = st; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(output int lat);
    lat = 0;
    while (!valid && lat < POLL_MAX) begin
      @(posedge clk); lat++; @(negedge clk);
    end
  endtask

  task automatic take();
    ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errs++; n_checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    int lat, nit;
    logic [63:0] r0, ex;
    n_checks = 0; n_errs = 0;
    rst_n = 1'b0; start = 1'b0; ready = 1'b0; wide = 1'b0; self_t = 1'b0;
    operand = '0; seed = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(valid == 1'b0, "R9 valid after reset", {63'd0, valid}, 64'd0);
    check(err == 1'b0, "R9 err after reset", {63'd0, err}, 64'd0);
    check(result == 64'd0, "R9 result after reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 even operand, then R11 error cleared by the next odd one
    launch(64'h0000_0000_0000_0010, 16'h0, 1'b1, 1'b0);
    wait_valid(lat);
    check(lat == 0, "R5 even completes at once", 64'(lat), 64'd0);
    check(err == 1'b1, "R5 even err", {63'd0, err}, 64'd1);
    check(result == 64'd0, "R5 even result", result, 64'd0);
    take();
    check(valid == 1'b0, "R6 release after even", {63'd0, valid}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] op;
      logic w, st;
      logic [15:0] sd;
      op = VEC[i][65:2]; w = VEC[i][1]; st = VEC[i][0];
      ex = exp_inv(op, w);
      sd = st ? 16'hBAD0 : ref_inv(op)[15:0];   // R4: garbage seed in self-test
      nit = st ? (w ? 5 : 4) : (w ? 2 : 1);
      launch(op, sd, w, st);
      wait_valid(lat);
      if (w) check(result == ex, "R2 64-bit inverse", result, ex);
      else   check(result == ex, "R1 32-bit inverse", result, ex);
      if (st) check(result == ex, "R4 self-test ignores seed", result, ex);
      else    check(result == ex, "R3 seeded refinement", result, ex);
      check(err == 1'b0, "R11 no error on odd", {63'd0, err}, 64'd0);
      check(lat == nit * 2 * (DW + 2), "R10 latency", 64'(lat), 64'(nit * 2 * (DW + 2)));
      take();
      check(valid == 1'b0, "R6 release", {63'd0, valid}, 64'd0);
    end

    // R6 hold while not ready; R7 start during pending result ignored
    ex = exp_inv(64'h0000_0000_0000_0013, 1'b1);
    launch(64'h0000_0000_0000_0013, ref_inv(64'h13)[15:0], 1'b1, 1'b0);
    wait_valid(lat);
    r0 = result;
    repeat (5) @(negedge clk);
    check(valid == 1'b1, "R6 valid held", {63'd0, valid}, 64'd1);
    check(result == r0, "R6 result held", result, r0);
    launch(64'h0000_0000_0000_0005, 16'h0, 1'b0, 1'b0);
    check(result == ex, "R7 start while valid ignored", result, ex);
    take();
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R7 no launch from ignored start", {63'd0, valid}, 64'd0);

    // R7 start during computation ignored
    ex = exp_inv(64'h0000_0000_0000_0029, 1'b0);
    launch(64'h0000_0000_0000_0029, ref_inv(64'h29)[15:0], 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    launch(64'hFFFF_0000_0000_0002, 16'h0, 1'b1, 1'b1);
    wait_valid(lat);
    check(result == ex, "R7 start while busy ignored", result, ex);
    check(err == 1'b0, "R7 busy start no error", {63'd0, err}, 64'd0);
    take();

    // R8 upper operand bits ignored in 32-bit mode
    launch(64'h0000_0000_1357_2469, ref_inv(64'h1357_2469)[15:0], 1'b0, 1'b0);
    wait_valid(lat);
    r0 = result;
    take();
    launch(64'h7777_ABCD_1357_2469, ref_inv(64'h1357_2469)[15:0], 1'b0, 1'b0);
    wait_valid(lat);
    check(result == r0, "R8 upper bits ignored", result, r0);
    check(result == exp_inv(64'h1357_2469, 1'b0), "R1 32-bit inverse upper op",
          result, exp_inv(64'h1357_2469, 1'b0));
    take();

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule